// File: doc/BRIEF.md
# Write-Back Set-Associative Data Cache

This block is an eight-way, 128-set data cache with 32-byte lines and a write-back policy. It sits between a processor load/store path and a line-wide memory port. The processor issues one request at a time. A request is either a word read or word write, or one of five line maintenance commands: zero a line, clean it (write back and keep), invalidate it (drop without write-back), flush it (write back and drop), or drop every way of a set whatever the tag. Reads and writes that miss allocate a line. The victim is an empty way if one exists; otherwise a tree pseudo-LRU picks it. A dirty victim is written back before the refill.

Both sides use valid/ready handshakes. On the processor side a request transfers on a cycle where `req_valid` and `req_ready` are both high. `req_ready` then stays low until the one-cycle `rsp_valid` pulse that ends that request. The response has no back-pressure. On the memory side the cache raises `mem_req_valid` and holds the write flag, address and write line constant until the cycle where `mem_req_ready` is high. For a read, the memory must present the line on `mem_rdata` in that same cycle.

Top module: `wbc_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is high, and `mem_req_valid` and `rsp_valid` are low.
- R2: Request opcodes are read=0, write=1, zero=2, clean=3, invalidate=4, flush=5, set-invalidate=6. A read returns the last value written to that word address, whether that value is held in the cache or in memory. A miss fetches the whole line with one memory read at the line-aligned address. Word k of a line occupies bits [32k+31:32k] of the 256-bit memory line.
- R3: Each accepted request produces exactly one single-cycle `rsp_valid`. `req_ready` is low from the accepting edge until that response.
- R4: A memory request keeps `mem_req_write`, `mem_req_addr` and `mem_req_wdata` stable until it is accepted. Its address is always 32-byte aligned. Memory traffic only occurs while a processor request is outstanding.
- R5: A miss in a set that has an invalid way fills an invalid way and evicts nothing. A hit causes no memory traffic.
- R6: With all eight ways valid, the victim follows a 7-bit tree pseudo-LRU that every hit and allocation updates. After lines A..H are allocated into an empty set in that order, the next miss evicts A, and B..H stay resident.
- R7: A dirty victim is written to its own stored line address before the refill read. A refilled line is valid and clean.
- R8: A write hit updates the word in the cache, marks the line modified, and causes no memory traffic.
- R9: Clean writes a valid modified line back and leaves it valid and unmodified. Clean on a clean line or on a miss causes no traffic.
- R10: Invalidate drops a matching line without write-back, so the modified data is lost and the next read refetches memory.
- R11: Flush writes a modified matching line back and then drops it. The next read refetches the flushed data.
- R12: Zero sets every byte of the addressed line to 0 and marks it modified without reading memory (a dirty victim is still written back first).
- R13: Set-invalidate drops every way of the addressed set, whatever the tag, with no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Cache can accept a request |
| req_op | input | 3 | Request opcode (see R2) |
| req_addr | input | 32 | Byte address; bits [11:5] select the set, [31:12] are the tag, [4:2] the word |
| req_wdata | input | 32 | Word to write |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with `rsp_valid` on a read |
| mem_req_valid | output | 1 | Line request to memory |
| mem_req_ready | input | 1 | Memory accepts the request; read line present |
| mem_req_write | output | 1 | 1 = write-back, 0 = refill read |
| mem_req_addr | output | 32 | Line-aligned memory address |
| mem_req_wdata | output | 256 | Line written back |
| mem_rdata | input | 256 | Refill line, sampled when `mem_req_ready` is high |

## Verification
A corrupted valid or modified bit shows up at the ports within one request. It appears as a memory read that should not happen, or one missing, on the next access to the line. It also appears as a write-back that is absent or extra on the next clean, flush or eviction, and is then seen as stale data on a read. A wrong tag or a wrong stored line address shows up as a write-back to the wrong memory line, which the following refetch exposes. Pseudo-LRU errors stay hidden until a full set misses; they are then caught by the choice of evicted line and by the traffic counts on the reads that follow.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_WRITE  = 3'd1,
    OP_ZERO   = 3'd2,
    OP_CLEAN  = 3'd3,
    OP_INVAL  = 3'd4,
    OP_FLUSH  = 3'd5,
    OP_SETINV = 3'd6
  } wbc_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_WB   = 2'd2,
    ST_FILL = 2'd3
  } wbc_state_e;
endpackage

// File: rtl/wbc_tag_match.sv
module wbc_tag_match #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 20,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS*TAG_W-1:0] way_tags,
  input  logic [WAYS-1:0]       way_valid,
  input  logic [TAG_W-1:0]      look_tag,
  output logic                  hit,
  output logic [WAY_W-1:0]      hit_way
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = way_valid[w] && (way_tags[w*TAG_W +: TAG_W] == look_tag);
  end

  assign hit = |match;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/wbc_victim.sv
module wbc_victim #(
  parameter int WAYS = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  way_valid,
  input  logic [WAYS-2:0]  tree,
  output logic [WAY_W-1:0] victim
);
  always_comb begin
    int node;
    victim = '0;
    node   = 0;
    if (!(&way_valid)) begin
      // lowest-numbered empty way wins
      for (int w = WAYS - 1; w >= 0; w--) begin
        if (!way_valid[w]) victim = WAY_W'(w);
      end
    end else begin
      // walk the tree: each node bit names the half to replace
      for (int l = 0; l < WAY_W; l++) begin
        victim[WAY_W-1-l] = tree[node];
        node = 2 * node + 1 + int'(tree[node]);
      end
    end
  end
endmodule

// File: rtl/wbc_plru_upd.sv
module wbc_plru_upd #(
  parameter int WAYS = 8,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-2:0]  tree_in,
  input  logic [WAY_W-1:0] used_way,
  output logic [WAYS-2:0]  tree_out
);
  always_comb begin
    int node;
    tree_out = tree_in;
    for (int l = 0; l < WAY_W; l++) begin
      // node on the path of used_way at depth l points to the other side
      node = (1 << l) - 1 + (int'(used_way) >> (WAY_W - l));
      tree_out[node] = ~used_way[WAY_W-1-l];
    end
  end
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
  import wbc_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 128,
  parameter int WAYS       = 8,
  parameter int LINE_BYTES = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [2:0]              req_op,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [31:0]             req_wdata,
  output logic                    rsp_valid,
  output logic [31:0]             rsp_rdata,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic                    mem_req_write,
  output logic [ADDR_W-1:0]       mem_req_addr,
  output logic [LINE_BYTES*8-1:0] mem_req_wdata,
  input  logic [LINE_BYTES*8-1:0] mem_rdata
);
  localparam int LINE_W = LINE_BYTES * 8;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WORD_W = OFF_W - 2;
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TREE_W = WAYS - 1;

  logic [TAG_W-1:0]  tag_q  [SETS][WAYS];
  logic [LINE_W-1:0] line_q [SETS][WAYS];
  logic [WAYS-1:0]   vld_q  [SETS];
  logic [WAYS-1:0]   mod_q  [SETS];
  logic [TREE_W-1:0] tree_q [SETS];

  wbc_state_e        state;
  wbc_op_e           r_op;
  logic [ADDR_W-1:0] r_addr;
  logic [31:0]       r_wdata;
  logic [WAY_W-1:0]  r_way;

  logic [IDX_W-1:0]      set_i;
  logic [TAG_W-1:0]      tag_i;
  logic [WORD_W-1:0]     word_i;
  logic [WAYS-1:0]       cur_vld, cur_mod;
  logic [TREE_W-1:0]     cur_tree, new_tree;
  logic [WAYS*TAG_W-1:0] tags_flat;
  logic                  hit, vict_dirty;
  logic [WAY_W-1:0]      hit_way, vict, used_way;
  logic [LINE_W-1:0]     hit_line;

  assign set_i      = r_addr[OFF_W +: IDX_W];
  assign tag_i      = r_addr[ADDR_W-1 -: TAG_W];
  assign word_i     = r_addr[2 +: WORD_W];
  assign cur_vld    = vld_q[set_i];
  assign cur_mod    = mod_q[set_i];
  assign cur_tree   = tree_q[set_i];
  assign hit_line   = line_q[set_i][hit_way];
  assign vict_dirty = cur_vld[vict] && cur_mod[vict];
  assign used_way   = hit ? hit_way : vict;

  for (genvar w = 0; w < WAYS; w++) begin : g_tags
    assign tags_flat[w*TAG_W +: TAG_W] = tag_q[set_i][w];
  end

  wbc_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .way_tags (tags_flat),
    .way_valid(cur_vld),
    .look_tag (tag_i),
    .hit      (hit),
    .hit_way  (hit_way)
  );

  wbc_victim #(.WAYS(WAYS)) u_victim (
    .way_valid(cur_vld),
    .tree     (cur_tree),
    .victim   (vict)
  );

  wbc_plru_upd #(.WAYS(WAYS)) u_plru (
    .tree_in (cur_tree),
    .used_way(used_way),
    .tree_out(new_tree)
  );

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_WB) || (state == ST_FILL);
  assign mem_req_write = (state == ST_WB);
  assign mem_req_addr  = (state == ST_WB) ? {tag_q[set_i][r_way], set_i, {OFF_W{1'b0}}}
                                          : {r_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_req_wdata = line_q[set_i][r_way];

  // line / tag array write port
  logic              arr_we, arr_tag_we;
  logic [WAY_W-1:0]  arr_way;
  logic [LINE_W-1:0] arr_line;

  always_comb begin
    arr_we     = 1'b0;
    arr_tag_we = 1'b0;
    arr_way    = hit_way;
    arr_line   = hit_line;
    if (state == ST_LOOK) begin
      if (r_op == OP_WRITE && hit) begin
        arr_we = 1'b1;
        arr_line[{word_i, 5'b0} +: 32] = r_wdata;
      end else if (r_op == OP_ZERO && (hit || !vict_dirty)) begin
        arr_we     = 1'b1;
        arr_tag_we = !hit;
        arr_way    = used_way;
        arr_line   = '0;
      end
    end else if (state == ST_FILL && mem_req_ready) begin
      arr_we     = 1'b1;
      arr_tag_we = 1'b1;
      arr_way    = r_way;
      arr_line   = mem_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (arr_we) begin
      line_q[set_i][arr_way] <= arr_line;
      if (arr_tag_we) tag_q[set_i][arr_way] <= tag_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      r_op      <= OP_READ;
      r_addr    <= '0;
      r_wdata   <= '0;
      r_way     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        mod_q[s]  <= '0;
        tree_q[s] <= '0;
      end
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (req_valid) begin
          r_op    <= wbc_op_e'(req_op);
          r_addr  <= req_addr;
          r_wdata <= req_wdata;
          state   <= ST_LOOK;
        end
        ST_LOOK: begin
          rsp_rdata <= hit_line[{word_i, 5'b0} +: 32];
          unique case (r_op)
            OP_READ, OP_WRITE, OP_ZERO: begin
              if (hit || (r_op == OP_ZERO && !vict_dirty)) begin
                tree_q[set_i] <= new_tree;
                vld_q[set_i][used_way] <= 1'b1;
                if (r_op != OP_READ) mod_q[set_i][used_way] <= 1'b1;
                rsp_valid <= 1'b1;
                state     <= ST_IDLE;
              end else begin
                r_way <= vict;
                state <= vict_dirty ? ST_WB : ST_FILL;
              end
            end
            OP_CLEAN, OP_FLUSH: begin
              if (hit && cur_mod[hit_way]) begin
                r_way <= hit_way;
                state <= ST_WB;
              end else begin
                if (hit && r_op == OP_FLUSH) vld_q[set_i][hit_way] <= 1'b0;
                rsp_valid <= 1'b1;
                state     <= ST_IDLE;
              end
            end
            OP_INVAL: begin
              if (hit) begin
                vld_q[set_i][hit_way] <= 1'b0;
                mod_q[set_i][hit_way] <= 1'b0;
              end
              rsp_valid <= 1'b1;
              state     <= ST_IDLE;
            end
            default: begin
              if (r_op == OP_SETINV) begin
                vld_q[set_i] <= '0;
                mod_q[set_i] <= '0;
              end
              rsp_valid <= 1'b1;
              state     <= ST_IDLE;
            end
          endcase
        end
        ST_WB: if (mem_req_ready) begin
          mod_q[set_i][r_way] <= 1'b0;
          if (r_op != OP_CLEAN) vld_q[set_i][r_way] <= 1'b0;
          if (r_op == OP_CLEAN || r_op == OP_FLUSH) begin
            rsp_valid <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            state <= ST_LOOK;
          end
        end
        ST_FILL: if (mem_req_ready) begin
          vld_q[set_i][r_way] <= 1'b1;
          mod_q[set_i][r_way] <= 1'b0;
          state <= ST_LOOK;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wbc_cache_chk.sv
module wbc_cache_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_write,
  input logic [ADDR_W-1:0] mem_req_addr
);
  logic pending;

  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 1'b0;
    else if (req_valid && req_ready) pending <= 1'b1;
    else if (rsp_valid) pending <= 1'b0;
  end

  // R4
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=>
      mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write));

  // R4
  mem_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr[4:0] == 5'd0);

  // R4
  mem_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> pending);

  // R3
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !rsp_valid |-> !req_ready);

  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R3
  rsp_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> pending);
endmodule

bind wbc_cache wbc_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write),
  .mem_req_addr (mem_req_addr)
);

// File: tb/wbc_cache_test.sv
`timescale 1ns/1ps
module wbc_cache_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [2:0]   req_op = '0;
  logic [31:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic         rsp_valid;
  logic [31:0]  rsp_rdata;
  logic         mem_req_valid;
  logic         mem_req_ready = 1'b0;
  logic         mem_req_write;
  logic [31:0]  mem_req_addr;
  logic [255:0] mem_req_wdata;
  logic [255:0] mem_rdata = '0;

  always #5 clk = ~clk;

  wbc_cache uut (.*);

  int n_chk = 0, n_bad = 0, rd_n = 0, wr_n = 0, dly = 0;
  bit finished = 0;
  logic [31:0] last_wr = '0;
  logic [255:0] mem [int unsigned];
  logic [31:0]  refm [int unsigned];

  localparam logic [2:0] RD = 3'd0, WR = 3'd1, ZR = 3'd2, CL = 3'd3,
                         IV = 3'd4, FL = 3'd5, SI = 3'd6;

  function automatic logic [31:0] mk(int t, int s, int w);
    return {t[19:0], s[6:0], w[2:0], 2'b00};
  endfunction

  function automatic logic [31:0] init_word(logic [31:0] a);
    return (a & ~32'h3) ^ 32'hA5C3_0F00;
  endfunction

  function automatic logic [255:0] line_of(logic [31:0] a);
    logic [255:0] l;
    if (mem.exists(a[31:5])) return mem[a[31:5]];
    for (int k = 0; k < 8; k++) l[32*k +: 32] = init_word({a[31:5], k[2:0], 2'b00});
    return l;
  endfunction

  function automatic logic [31:0] mem_word(logic [31:0] a);
    logic [255:0] l = line_of(a);
    return l[{a[4:2], 5'b0} +: 32];
  endfunction

  function automatic logic [31:0] ref_get(logic [31:0] a);
    if (refm.exists(a[31:2])) return refm[a[31:2]];
    return mem_word(a);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // behavioural line memory with random acceptance delay
  always @(negedge clk) begin
    if (mem_req_ready) mem_req_ready = 1'b0;
    else if (mem_req_valid) begin
      if (dly > 0) dly--;
      else begin
        chk("R4 align", {27'd0, mem_req_addr[4:0]}, 32'd0);
        if (mem_req_write) begin
          mem[mem_req_addr[31:5]] = mem_req_wdata;
          wr_n++;
          last_wr = mem_req_addr;
        end else begin
          mem_rdata = line_of(mem_req_addr);
          rd_n++;
        end
        mem_req_ready = 1'b1;
        dly = $urandom % 4;
      end
    end
  end

  task automatic do_op(input logic [2:0] op, input logic [31:0] a,
                       input logic [31:0] d, output logic [31:0] rd);
    int t = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R3 busy", {31'd0, req_ready}, 32'd0);
    while (!rsp_valid && t < 1000) begin @(negedge clk); t++; end
    chk("R3 response", {31'd0, rsp_valid}, 32'd1);
    rd = rsp_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int r0, w0;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 ready", {31'd0, req_ready}, 32'd1);
    chk("R1 memreq", {31'd0, mem_req_valid}, 32'd0);
    chk("R1 rsp", {31'd0, rsp_valid}, 32'd0);
    rst_n = 1'b1;

    // R2 read miss then R5 hit
    r0 = rd_n; do_op(RD, mk(1,3,2), 0, v);
    chk("R2 miss data", v, init_word(mk(1,3,2)));
    chk("R2 one refill", rd_n - r0, 1);
    r0 = rd_n; do_op(RD, mk(1,3,2), 0, v);
    chk("R5 hit no traffic", rd_n - r0, 0);

    // R8 write hit
    r0 = rd_n; w0 = wr_n; do_op(WR, mk(1,3,2), 32'hDEAD0001, v);
    chk("R8 no traffic", (rd_n - r0) + (wr_n - w0), 0);
    do_op(RD, mk(1,3,2), 0, v); chk("R8 readback", v, 32'hDEAD0001);

    // R9 clean
    w0 = wr_n; do_op(CL, mk(1,3,0), 0, v);
    chk("R9 one writeback", wr_n - w0, 1);
    chk("R9 address", last_wr, mk(1,3,0));
    chk("R9 memory data", mem_word(mk(1,3,2)), 32'hDEAD0001);
    r0 = rd_n; do_op(RD, mk(1,3,2), 0, v);
    chk("R9 still valid", rd_n - r0, 0);
    w0 = wr_n; do_op(CL, mk(1,3,0), 0, v);
    chk("R9 clean line silent", wr_n - w0, 0);

    // R10 invalidate discards dirty word
    do_op(WR, mk(1,3,1), 32'hBEEF0002, v);
    w0 = wr_n; do_op(IV, mk(1,3,1), 0, v);
    chk("R10 no writeback", wr_n - w0, 0);
    r0 = rd_n; do_op(RD, mk(1,3,1), 0, v);
    chk("R10 stale memory", v, init_word(mk(1,3,1)));
    chk("R10 refetch", rd_n - r0, 1);

    // R11 flush
    do_op(WR, mk(1,3,0), 32'hCAFE0003, v);
    w0 = wr_n; do_op(FL, mk(1,3,0), 0, v);
    chk("R11 writeback", wr_n - w0, 1);
    chk("R11 memory data", mem_word(mk(1,3,0)), 32'hCAFE0003);
    r0 = rd_n; do_op(RD, mk(1,3,0), 0, v);
    chk("R11 refetch", rd_n - r0, 1);
    chk("R11 data", v, 32'hCAFE0003);

    // R12 zero allocates without refill
    r0 = rd_n; do_op(ZR, mk(5,3,0), 0, v);
    chk("R12 no refill", rd_n - r0, 0);
    do_op(RD, mk(5,3,4), 0, v); chk("R12 zero word", v, 32'd0);
    w0 = wr_n; do_op(FL, mk(5,3,0), 0, v);
    chk("R12 modified", wr_n - w0, 1);
    chk("R12 memory zero", mem_word(mk(5,3,7)), 32'd0);

    // R13 set invalidate by foreign tag
    do_op(WR, mk(6,3,0), 32'h0000_0444, v);
    do_op(WR, mk(7,3,0), 32'h0000_0555, v);
    w0 = wr_n; do_op(SI, mk(99,3,0), 0, v);
    chk("R13 no writeback", wr_n - w0, 0);
    r0 = rd_n;
    do_op(RD, mk(6,3,0), 0, v); chk("R13 tag6 dropped", v, init_word(mk(6,3,0)));
    do_op(RD, mk(7,3,0), 0, v); chk("R13 tag7 dropped", v, init_word(mk(7,3,0)));
    chk("R13 refetches", rd_n - r0, 2);

    // R5 R6 R7 replacement in set 9
    r0 = rd_n; w0 = wr_n;
    for (int t = 10; t < 18; t++) do_op(WR, mk(t,9,0), 32'h1000_0000 + t, v);
    chk("R5 fills", rd_n - r0, 8);
    chk("R5 no eviction", wr_n - w0, 0);
    r0 = rd_n; w0 = wr_n; do_op(RD, mk(18,9,0), 0, v);
    chk("R7 one writeback", wr_n - w0, 1);
    chk("R6 oldest victim", last_wr, mk(10,9,0));
    chk("R7 victim data", mem_word(mk(10,9,0)), 32'h1000_000A);
    chk("R2 new line", v, init_word(mk(18,9,0)));
    r0 = rd_n;
    for (int t = 11; t < 18; t++) begin
      do_op(RD, mk(t,9,0), 0, v);
      chk("R6 resident", v, 32'h1000_0000 + t);
    end
    chk("R6 no misses", rd_n - r0, 0);
    r0 = rd_n; do_op(RD, mk(10,9,0), 0, v);
    chk("R6 evicted refetch", rd_n - r0, 1);
    chk("R7 data kept", v, 32'h1000_000A);

    // random mix on two sets with many tags (R2)
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, d;
      int sel;
      a = mk($urandom % 12, $urandom % 2, $urandom % 8);
      d = $urandom;
      sel = $urandom % 10;
      if (sel < 4) begin
        do_op(RD, a, 0, v); chk("R2 random read", v, ref_get(a));
      end else if (sel < 7) begin
        do_op(WR, a, d, v); refm[a[31:2]] = d;
      end else if (sel == 7) begin
        do_op(ZR, a, 0, v);
        for (int k = 0; k < 8; k++) refm[{a[31:5], k[2:0]}] = 32'd0;
      end else if (sel == 8) do_op(CL, a, 0, v);
      else do_op(FL, a, 0, v);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule